// File: doc/BRIEF.md
# Segmented Virtual Address Translator

This unit turns a 32-bit virtual address into a physical address for a processor core. The address space is cut into fixed regions. Two upper regions are translated by subtracting a constant base. The low half of the space and the top quarter go through a small, fully associative translation table. A user-mode access to the upper half fails before any lookup is made. When the error-level flag is set, the low half is passed through unchanged.

Each table entry covers a pair of adjacent 4 KiB pages. Address bit 12 picks the even or the odd half, and each half has its own frame number, valid bit and dirty bit. An entry matches on its virtual page tag, an upper address bound, and either a global flag or an equal address-space ID. A lookup returns a physical address, read and write permission bits, and one of five result codes.

Requests are strobed in, and the result comes back on the following cycle. Table entries are loaded through a single indexed write port.

Top module: `xlat_unit`

## Requirements
- R1: In user mode, any address with bit 31 set returns result code 1 (address error) with paddr 0 and both permissions clear. A user address of 0x7FFFFFFF or below is looked up normally.
- R2: An address below 0x80000000 with the error-level flag set returns code 0 (hit), with paddr equal to vaddr and both permissions set. This holds in both modes.
- R3: In kernel mode, addresses 0x80000000..0x9FFFFFFF give paddr = vaddr - 0x80000000, and addresses 0xA0000000..0xBFFFFFFF give paddr = vaddr - 0xA0000000. Both ranges return code 0 with read and write allowed.
- R4: Addresses below 0x80000000 without the error-level flag, and all kernel addresses from 0xC0000000 up, use the table. The error-level flag has no effect on the upper range. If no entry matches, the result is code 2 (miss) with paddr 0 and no permissions.
- R5: An entry matches when its tag equals vaddr[31:13], vaddr is strictly below the entry's end bound, and either its global bit is set or its ASID equals asid_i.
- R6: vaddr[12] selects the odd (1) or even (0) half of the matching entry. On a hit, paddr = {frame of that half, vaddr[11:0]}.
- R7: A matching entry whose selected half has its valid bit clear returns code 3 (invalid), for reads and for writes.
- R8: A write to a valid half whose dirty bit is clear returns code 4 (modified) with no permissions. A read of the same half is a hit with read permission only.
- R9: A hit on a valid half with its dirty bit set grants both read and write permission.
- R10: When several entries match, the entry with the lowest index is used.
- R11: rsp_valid_o is high in exactly the cycle after each cycle in which req_valid_i is high. The result outputs keep their last values while no request arrives.
- R12: A table write takes effect for lookups from the next cycle on. A lookup made in the same cycle as the write sees the old contents.
- R13: Reset clears rsp_valid_o, paddr_o, both permissions and result_o, and leaves no entry able to match, so every table lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request strobe |
| vaddr_i | input | 32 | Virtual address |
| write_i | input | 1 | 1 = store access, 0 = load |
| user_mode_i | input | 1 | 1 = user mode, 0 = kernel mode |
| err_level_i | input | 1 | Error-level flag: low half is passed through unmapped |
| asid_i | input | 8 | Current address-space ID |
| tlb_we_i | input | 1 | Table write enable |
| tlb_idx_i | input | $clog2(TLB_ENTRIES) | Entry index to write |
| tlb_vpn_i | input | 19 | Tag (virtual address bits 31:13) |
| tlb_asid_i | input | 8 | Entry ASID |
| tlb_global_i | input | 1 | Entry matches any ASID |
| tlb_end_i | input | 32 | Exclusive upper address bound |
| tlb_pfn_even_i | input | 20 | Frame number, even page |
| tlb_pfn_odd_i | input | 20 | Frame number, odd page |
| tlb_valid_even_i | input | 1 | Valid, even page |
| tlb_valid_odd_i | input | 1 | Valid, odd page |
| tlb_dirty_even_i | input | 1 | Writable, even page |
| tlb_dirty_odd_i | input | 1 | Writable, odd page |
| rsp_valid_o | output | 1 | Result valid |
| paddr_o | output | 32 | Physical address |
| rd_ok_o | output | 1 | Read permitted |
| wr_ok_o | output | 1 | Write permitted |
| result_o | output | 3 | 0 hit, 1 address error, 2 miss, 3 invalid, 4 modified |

## Verification
Every result is registered once, so a request strobed at one rising edge has its outputs valid from that edge until the next one. The bench drives inputs on the falling edge and reads the outputs at the following falling edge, which is the only cycle in which rsp_valid_o is high for that request. Table writes also land on one edge. The same-cycle case checks that a lookup issued together with a write still sees the old entry, and the request on the following cycle sees the new one.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int VA_W   = 32;
  localparam int OFF_W  = 12;
  localparam int VPN_W  = VA_W - OFF_W - 1;
  localparam int PFN_W  = VA_W - OFF_W;
  localparam int ASID_W = 8;

  typedef enum logic [2:0] {
    RES_HIT      = 3'd0,
    RES_ADDR_ERR = 3'd1,
    RES_MISS     = 3'd2,
    RES_INVALID  = 3'd3,
    RES_MODIFIED = 3'd4
  } xlat_res_e;

  typedef struct packed {
    logic [VPN_W-1:0]       vpn;
    logic [ASID_W-1:0]      asid;
    logic                   glob;
    logic [VA_W-1:0]        end_a;
    logic [1:0][PFN_W-1:0]  pfn;    // [0] even, [1] odd
    logic [1:0]             valid;
    logic [1:0]             dirty;
  } tlb_entry_t;
endpackage

// File: rtl/xlat_seg_decode.sv
module xlat_seg_decode
  import xlat_pkg::*;
(
  input  logic [VA_W-1:0] vaddr_i,
  input  logic            user_mode_i,
  input  logic            err_level_i,
  output logic            seg_err_o,
  output logic            seg_mapped_o,
  output logic [VA_W-1:0] direct_pa_o
);
  localparam logic [VA_W-1:0] CACHED_BASE   = 32'h8000_0000;
  localparam logic [VA_W-1:0] UNCACHED_BASE = 32'hA000_0000;

  always_comb begin
    seg_err_o    = user_mode_i & vaddr_i[VA_W-1];
    seg_mapped_o = 1'b0;
    direct_pa_o  = vaddr_i;
    if (!vaddr_i[VA_W-1]) begin
      seg_mapped_o = !err_level_i;
    end else if (vaddr_i[VA_W-1 -: 3] == 3'b100) begin
      direct_pa_o = vaddr_i - CACHED_BASE;
    end else if (vaddr_i[VA_W-1 -: 3] == 3'b101) begin
      direct_pa_o = vaddr_i - UNCACHED_BASE;
    end else begin
      seg_mapped_o = 1'b1;
    end
  end
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  tlb_entry_t        wentry_i,
  input  logic [VA_W-1:0]   vaddr_i,
  input  logic [ASID_W-1:0] asid_i,
  output logic              hit_o,
  output tlb_entry_t        hit_entry_o
);
  tlb_entry_t           tbl_q [ENTRIES];
  logic [ENTRIES-1:0]   match;
  logic [ENTRIES-1:0]   sel_oh;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     tbl_q[g] <= '0;
      else if (we_i && widx_i == IDX_W'(g))            tbl_q[g] <= wentry_i;
    end
    assign match[g] = (tbl_q[g].glob || tbl_q[g].asid == asid_i) &&
                      (tbl_q[g].vpn == vaddr_i[VA_W-1 -: VPN_W]) &&
                      (vaddr_i < tbl_q[g].end_a);
  end

  // lowest index wins
  always_comb begin
    sel_oh = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) sel_oh = ENTRIES'(1) << i;
    end
  end

  always_comb begin
    hit_entry_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (sel_oh[i]) hit_entry_o = tbl_q[i];
    end
  end

  assign hit_o = |sel_oh;

  assert_one_winner_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_oh));
  assert_winner_matches_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_oh & ~match) == '0 && (hit_o == (match != '0)));
  assert_write_lands_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> tbl_q[$past(widx_i)] == $past(wentry_i));
endmodule

// File: rtl/xlat_resolve.sv
module xlat_resolve
  import xlat_pkg::*;
(
  input  logic            seg_err_i,
  input  logic            seg_mapped_i,
  input  logic [VA_W-1:0] direct_pa_i,
  input  logic            tlb_hit_i,
  input  tlb_entry_t      entry_i,
  input  logic [VA_W-1:0] vaddr_i,
  input  logic            write_i,
  output xlat_res_e       res_o,
  output logic [VA_W-1:0] paddr_o,
  output logic            rd_ok_o,
  output logic            wr_ok_o
);
  logic odd;
  assign odd = vaddr_i[OFF_W];

  always_comb begin
    res_o   = RES_HIT;
    paddr_o = '0;
    rd_ok_o = 1'b0;
    wr_ok_o = 1'b0;
    if (seg_err_i) begin
      res_o = RES_ADDR_ERR;
    end else if (!seg_mapped_i) begin
      paddr_o = direct_pa_i;
      rd_ok_o = 1'b1;
      wr_ok_o = 1'b1;
    end else if (!tlb_hit_i) begin
      res_o = RES_MISS;
    end else if (!entry_i.valid[odd]) begin
      res_o = RES_INVALID;
    end else if (write_i && !entry_i.dirty[odd]) begin
      res_o = RES_MODIFIED;
    end else begin
      paddr_o = {entry_i.pfn[odd], vaddr_i[OFF_W-1:0]};
      rd_ok_o = 1'b1;
      wr_ok_o = entry_i.dirty[odd];
    end
  end
endmodule

// File: rtl/xlat_unit.sv
module xlat_unit
  import xlat_pkg::*;
#(
  parameter int TLB_ENTRIES = 16,
  localparam int IDX_W = (TLB_ENTRIES > 1) ? $clog2(TLB_ENTRIES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [31:0]       vaddr_i,
  input  logic              write_i,
  input  logic              user_mode_i,
  input  logic              err_level_i,
  input  logic [7:0]        asid_i,
  input  logic              tlb_we_i,
  input  logic [IDX_W-1:0]  tlb_idx_i,
  input  logic [18:0]       tlb_vpn_i,
  input  logic [7:0]        tlb_asid_i,
  input  logic              tlb_global_i,
  input  logic [31:0]       tlb_end_i,
  input  logic [19:0]       tlb_pfn_even_i,
  input  logic [19:0]       tlb_pfn_odd_i,
  input  logic              tlb_valid_even_i,
  input  logic              tlb_valid_odd_i,
  input  logic              tlb_dirty_even_i,
  input  logic              tlb_dirty_odd_i,
  output logic              rsp_valid_o,
  output logic [31:0]       paddr_o,
  output logic              rd_ok_o,
  output logic              wr_ok_o,
  output logic [2:0]        result_o
);
  logic            seg_err, seg_mapped, tlb_hit;
  logic [VA_W-1:0] direct_pa, paddr_d;
  tlb_entry_t      wentry, hit_entry;
  xlat_res_e       res_d;
  logic            rd_d, wr_d;

  always_comb begin
    wentry       = '0;
    wentry.vpn   = tlb_vpn_i;
    wentry.asid  = tlb_asid_i;
    wentry.glob  = tlb_global_i;
    wentry.end_a = tlb_end_i;
    wentry.pfn   = {tlb_pfn_odd_i, tlb_pfn_even_i};
    wentry.valid = {tlb_valid_odd_i, tlb_valid_even_i};
    wentry.dirty = {tlb_dirty_odd_i, tlb_dirty_even_i};
  end

  xlat_seg_decode i_seg (
    .vaddr_i      (vaddr_i),
    .user_mode_i  (user_mode_i),
    .err_level_i  (err_level_i),
    .seg_err_o    (seg_err),
    .seg_mapped_o (seg_mapped),
    .direct_pa_o  (direct_pa)
  );

  xlat_tlb #(.ENTRIES(TLB_ENTRIES)) i_tlb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (tlb_we_i),
    .widx_i      (tlb_idx_i),
    .wentry_i    (wentry),
    .vaddr_i     (vaddr_i),
    .asid_i      (asid_i),
    .hit_o       (tlb_hit),
    .hit_entry_o (hit_entry)
  );

  xlat_resolve i_res (
    .seg_err_i    (seg_err),
    .seg_mapped_i (seg_mapped),
    .direct_pa_i  (direct_pa),
    .tlb_hit_i    (tlb_hit),
    .entry_i      (hit_entry),
    .vaddr_i      (vaddr_i),
    .write_i      (write_i),
    .res_o        (res_d),
    .paddr_o      (paddr_d),
    .rd_ok_o      (rd_d),
    .wr_ok_o      (wr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      paddr_o     <= '0;
      rd_ok_o     <= 1'b0;
      wr_ok_o     <= 1'b0;
      result_o    <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        paddr_o  <= paddr_d;
        rd_ok_o  <= rd_d;
        wr_ok_o  <= wr_d;
        result_o <= res_d;
      end
    end
  end

  assert_rsp_latency_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  assert_rsp_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!rsp_valid_o && $stable(paddr_o) && $stable(result_o)));
  assert_user_err_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && user_mode_i && vaddr_i[31]) |=>
      (result_o == RES_ADDR_ERR && !rd_ok_o && !wr_ok_o));
  assert_kseg_direct_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !user_mode_i && vaddr_i[31:30] == 2'b10) |=>
      (result_o == RES_HIT && paddr_o[31:29] == 3'b000 &&
       paddr_o[28:0] == $past(vaddr_i[28:0])));
  assert_fail_no_perm_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && result_o != RES_HIT) |-> (!rd_ok_o && !wr_ok_o && paddr_o == '0));
  assert_wr_needs_rd_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ok_o |-> rd_ok_o);
endmodule

// File: tb/test_xlat_unit.sv
module test_xlat_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, wr = 1'b0, usr = 1'b0, erl = 1'b0;
  logic [31:0] va = '0;
  logic [7:0]  asid = '0;
  logic        twe = 1'b0, tglob = 1'b0;
  logic [3:0]  tidx = '0;
  logic [18:0] tvpn = '0;
  logic [7:0]  tasid = '0;
  logic [31:0] tend = '0;
  logic [19:0] tpfn0 = '0, tpfn1 = '0;
  logic        tv0 = 1'b0, tv1 = 1'b0, td0 = 1'b0, td1 = 1'b0;
  logic        rsp_valid, rd_ok, wr_ok;
  logic [31:0] paddr;
  logic [2:0]  result;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  xlat_unit #(.TLB_ENTRIES(16)) i_xlat_unit (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req), .vaddr_i(va), .write_i(wr),
    .user_mode_i(usr), .err_level_i(erl), .asid_i(asid),
    .tlb_we_i(twe), .tlb_idx_i(tidx), .tlb_vpn_i(tvpn), .tlb_asid_i(tasid),
    .tlb_global_i(tglob), .tlb_end_i(tend), .tlb_pfn_even_i(tpfn0),
    .tlb_pfn_odd_i(tpfn1), .tlb_valid_even_i(tv0), .tlb_valid_odd_i(tv1),
    .tlb_dirty_even_i(td0), .tlb_dirty_odd_i(td1),
    .rsp_valid_o(rsp_valid), .paddr_o(paddr), .rd_ok_o(rd_ok), .wr_ok_o(wr_ok),
    .result_o(result)
  );

  typedef struct packed {
    logic [31:0] va;
    logic        wr;
    logic        usr;
    logic        erl;
    logic [7:0]  asid;
    logic [2:0]  res;
    logic [31:0] pa;
    logic        rd;
    logic        wok;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{32'h8000_0000, 1'b0, 1'b1, 1'b0, 8'd5, 3'd1, 32'h0, 1'b0, 1'b0, 4'd1},        // R1
    '{32'hFFFF_FFFC, 1'b1, 1'b1, 1'b0, 8'd5, 3'd1, 32'h0, 1'b0, 1'b0, 4'd1},        // R1
    '{32'h7FFF_FFFF, 1'b0, 1'b1, 1'b0, 8'd5, 3'd2, 32'h0, 1'b0, 1'b0, 4'd1},        // R1 boundary
    '{32'h0040_0010, 1'b1, 1'b0, 1'b1, 8'd5, 3'd0, 32'h0040_0010, 1'b1, 1'b1, 4'd2}, // R2
    '{32'h0000_1000, 1'b0, 1'b1, 1'b1, 8'd5, 3'd0, 32'h0000_1000, 1'b1, 1'b1, 4'd2}, // R2 user
    '{32'h8000_1234, 1'b0, 1'b0, 1'b0, 8'd5, 3'd0, 32'h0000_1234, 1'b1, 1'b1, 4'd3}, // R3
    '{32'h9FFF_FFFF, 1'b1, 1'b0, 1'b0, 8'd5, 3'd0, 32'h1FFF_FFFF, 1'b1, 1'b1, 4'd3}, // R3
    '{32'hA000_0010, 1'b0, 1'b0, 1'b0, 8'd5, 3'd0, 32'h0000_0010, 1'b1, 1'b1, 4'd3}, // R3
    '{32'hBFFF_FFFF, 1'b0, 1'b0, 1'b0, 8'd5, 3'd0, 32'h1FFF_FFFF, 1'b1, 1'b1, 4'd3}, // R3
    '{32'h1000_0000, 1'b0, 1'b0, 1'b0, 8'd5, 3'd2, 32'h0, 1'b0, 1'b0, 4'd4},        // R4
    '{32'hE000_0000, 1'b0, 1'b0, 1'b0, 8'd5, 3'd2, 32'h0, 1'b0, 1'b0, 4'd4},        // R4
    '{32'hC001_0008, 1'b0, 1'b0, 1'b1, 8'd5, 3'd0, 32'h0111_1008, 1'b1, 1'b1, 4'd4}, // R4 erl no effect
    '{32'h0040_0ABC, 1'b0, 1'b1, 1'b0, 8'd5, 3'd0, 32'h1234_5ABC, 1'b1, 1'b1, 4'd6}, // R6 R9 R10
    '{32'h0040_1ABC, 1'b1, 1'b1, 1'b0, 8'd5, 3'd4, 32'h0, 1'b0, 1'b0, 4'd8},        // R8
    '{32'h0040_1ABC, 1'b0, 1'b1, 1'b0, 8'd5, 3'd0, 32'h2345_6ABC, 1'b1, 1'b0, 4'd8}, // R8
    '{32'h0040_0ABC, 1'b0, 1'b1, 1'b0, 8'd7, 3'd0, 32'h5555_5ABC, 1'b1, 1'b1, 4'd10}, // R10 R5
    '{32'h0040_2004, 1'b1, 1'b1, 1'b0, 8'd5, 3'd3, 32'h0, 1'b0, 1'b0, 4'd7},        // R7
    '{32'h0040_2004, 1'b0, 1'b1, 1'b0, 8'd5, 3'd3, 32'h0, 1'b0, 1'b0, 4'd7},        // R7
    '{32'h0040_3004, 1'b0, 1'b1, 1'b0, 8'd9, 3'd0, 32'h0BBB_B004, 1'b1, 1'b1, 4'd9}, // R9 R6
    '{32'hC001_0008, 1'b0, 1'b0, 1'b0, 8'd6, 3'd2, 32'h0, 1'b0, 1'b0, 4'd5},        // R5 asid
    '{32'h0060_0FFF, 1'b0, 1'b1, 1'b0, 8'd0, 3'd0, 32'h0333_3FFF, 1'b1, 1'b1, 4'd5}, // R5 bound
    '{32'h0060_1000, 1'b0, 1'b1, 1'b0, 8'd0, 3'd2, 32'h0, 1'b0, 1'b0, 4'd5}         // R5 bound
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tlb_write(input logic [3:0] idx, input logic [18:0] vpn, input logic [7:0] a,
                           input logic g, input logic [31:0] e, input logic [19:0] p0,
                           input logic [19:0] p1, input logic v0, input logic v1,
                           input logic d0, input logic d1);
    @(negedge clk);
    twe = 1'b1; tidx = idx; tvpn = vpn; tasid = a; tglob = g; tend = e;
    tpfn0 = p0; tpfn1 = p1; tv0 = v0; tv1 = v1; td0 = d0; td1 = d1;
    @(negedge clk);
    twe = 1'b0;
  endtask

  task automatic issue(input logic [31:0] a, input logic w, input logic u,
                       input logic e, input logic [7:0] s);
    @(negedge clk);
    req = 1'b1; va = a; wr = w; usr = u; erl = e; asid = s;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic check_rsp(input string tag, input logic [2:0] r, input logic [31:0] p,
                           input logic rdx, input logic wrx);
    check({tag, " valid"}, 32'(rsp_valid), 32'd1);
    check({tag, " result"}, 32'(result), 32'(r));
    check({tag, " paddr"}, paddr, p);
    check({tag, " perm"}, {30'd0, rd_ok, wr_ok}, {30'd0, rdx, wrx});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13 reset state
    check("R13 rsp_valid", 32'(rsp_valid), 32'd0);
    check("R13 outputs", {paddr[28:0], result}, 32'd0);
    check("R13 perms", {30'd0, rd_ok, wr_ok}, 32'd0);
    rst_n = 1'b1;
    issue(32'h0040_0ABC, 1'b0, 1'b0, 1'b0, 8'd5);
    check_rsp("R13 empty table miss", 3'd2, 32'h0, 1'b0, 1'b0);

    tlb_write(4'd0, 19'h00200, 8'd5, 1'b0, 32'h0040_4000, 20'h12345, 20'h23456, 1, 1, 1, 0);
    tlb_write(4'd1, 19'h00201, 8'd0, 1'b1, 32'hFFFF_FFFF, 20'h0AAAA, 20'h0BBBB, 0, 1, 1, 1);
    tlb_write(4'd2, 19'h00200, 8'd0, 1'b1, 32'h0040_4000, 20'h55555, 20'h66666, 1, 1, 1, 1);
    tlb_write(4'd3, 19'h60008, 8'd5, 1'b0, 32'hC001_4000, 20'h01111, 20'h02222, 1, 1, 1, 1);
    tlb_write(4'd4, 19'h00300, 8'd0, 1'b1, 32'h0060_1000, 20'h03333, 20'h04444, 1, 1, 1, 1);

    for (int i = 0; i < NV; i++) begin
      issue(VECS[i].va, VECS[i].wr, VECS[i].usr, VECS[i].erl, VECS[i].asid);
      check_rsp($sformatf("R%0d vec%0d", VECS[i].rq, i), VECS[i].res, VECS[i].pa,
                VECS[i].rd, VECS[i].wok);
    end

    // R11: no request -> valid low, outputs held
    @(negedge clk);
    check("R11 idle valid", 32'(rsp_valid), 32'd0);
    check("R11 held result", 32'(result), 32'd2);

    // R12: same-cycle write sees old contents, next cycle new
    @(negedge clk);
    twe = 1'b1; tidx = 4'd5; tvpn = 19'h00500; tasid = 8'd0; tglob = 1'b1;
    tend = 32'hFFFF_FFFF; tpfn0 = 20'h07777; tpfn1 = 20'h08888;
    tv0 = 1; tv1 = 1; td0 = 1; td1 = 1;
    req = 1'b1; va = 32'h00A0_0100; wr = 1'b0; usr = 1'b0; erl = 1'b0; asid = 8'd3;
    @(negedge clk);
    twe = 1'b0; req = 1'b0;
    check("R12 same-cycle old", 32'(result), 32'd2);
    issue(32'h00A0_0100, 1'b0, 1'b0, 1'b0, 8'd3);
    check_rsp("R12 next-cycle new", 3'd0, 32'h0777_7100, 1'b1, 1'b1);

    // R13: reset again clears table
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R13 reapplied valid", 32'(rsp_valid), 32'd0);
    rst_n = 1'b1;
    issue(32'h00A0_0100, 1'b0, 1'b0, 1'b0, 8'd3);
    check_rsp("R13 table cleared", 3'd2, 32'h0, 1'b0, 1'b0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule